// File: doc/BRIEF.md
# Relocatable Multiplexed-Bus Address Decoder

This block sits at the front of a bus peripheral on a multiplexed 8-bit address/data bus. Every input is sampled in a system clock. When the address strobe is seen to fall, the block captures a 16-bit address. The upper byte comes from dedicated address lines and the lower byte from the shared AD lines. The block also records whether the chip was selected at that moment.

The block compares the captured address against two relocatable windows:
- a 1 KB register window, whose base comes from a register-map byte;
- an 8 KB memory window, whose base comes from a memory-map byte.

Where the two windows overlap, the register window wins. The block outputs a hit flag for each window, the internal offset, and the memory plane (one of two 4 KB halves). It also flags the 16-byte scratch area inside the register window. It produces a read enable and a one-cycle write pulse with the captured write data. It returns read data combinationally from the selected target. The two map bytes read back inverted.

A bit of the memory-map byte turns port B into a copy of the captured low address byte. Another bit of that byte sets the polarity of the reset pin.

Top module: `mux_addr_decoder`

## Requirements
- R1: The address {addr_hi, ad_in} is captured at the clock edge where bus_as is first sampled low after being sampled high. It stays unchanged until the next such edge.
- R2: An access is valid only if bus_ce is 1 and bus_sel_n is 0 at the capturing edge. Without a valid access, there is no hit, no rd_en and no wr_en.
- R3: reg_hit is 1 when the access is valid, reg_map[7:6] equals 2'b10, and address bits 15:10 equal reg_map[5:0]. In that case offset = {3'b000, addr[9:0]}.
- R4: mem_hit is 1 when the access is valid, there is no reg_hit, and address bits 15:13 equal mem_map[2:0]. In that case offset = addr[12:0] and plane = addr[12]. When neither window is hit, offset and plane are 0.
- R5: If an address falls in both windows, only reg_hit is asserted.
- R6: rd_en = hit AND bus_e AND bus_rw. ad_out follows the target's read data combinationally: reg_rdata for a register hit, mem_rdata for a memory hit, and 0 when nothing is hit.
- R7: In the register window, offset 000h reads ~reg_map and offset 038h reads ~mem_map. These override reg_rdata.
- R8: wr_en is a one-cycle pulse, given only on a hit. It is high in the cycle after the clock edge where bus_e is first sampled low after high, provided bus_rw was sampled low at the edge before. wr_data holds ad_in sampled at that same edge.
- R9: scratch_hit is 1 on a register hit with offset 200h through 20Fh.
- R10: When mem_map[5] is 1, portb_out equals the captured address bits 7:0. Otherwise portb_out equals gpio_b.
- R11: When mem_map[3] is 0, rst_pin is active low; when it is 1, rst_pin is active high. Reset is synchronous and clears the valid flag and wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin | input | 1 | Reset, polarity from mem_map[3] |
| bus_as | input | 1 | Address strobe |
| bus_e | input | 1 | Data phase clock |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_ce | input | 1 | Chip enable, active high |
| bus_sel_n | input | 1 | Select, active low |
| addr_hi | input | 8 | High address byte |
| ad_in | input | 8 | Multiplexed low address / write data |
| reg_map | input | 8 | Register window map byte |
| mem_map | input | 8 | Memory window map byte |
| reg_rdata | input | 8 | Read data from register file |
| mem_rdata | input | 8 | Read data from memory planes |
| gpio_b | input | 8 | Port B general I/O value |
| ad_out | output | 8 | Read data to bus |
| wr_data | output | 8 | Captured write data |
| portb_out | output | 8 | Port B output |
| rd_en | output | 1 | Read enable |
| wr_en | output | 1 | Write pulse |
| reg_hit | output | 1 | Register window hit |
| mem_hit | output | 1 | Memory window hit |
| scratch_hit | output | 1 | Scratch RAM hit |
| plane | output | 1 | Memory plane select |
| offset | output | 13 | Offset within hit window |

## Verification
The captured address, and so the hit, offset, plane and port B results, is due one clock edge after the strobe is first driven low. The bench drives on falling clock edges, so it reads these values at the next falling edge. rd_en and ad_out are combinational in bus_e and bus_rw. The bench checks them 1 ns after raising E, within the same low clock phase. The write pulse needs two registered stages, E high and then E low. The bench checks it one falling edge after E is dropped, and checks again one cycle later that the pulse is gone.

// File: rtl/mux_addr_decoder.sv
module mux_addr_decoder (
  input  logic        clk,
  input  logic        rst_pin,
  input  logic        bus_as,
  input  logic        bus_e,
  input  logic        bus_rw,
  input  logic        bus_ce,
  input  logic        bus_sel_n,
  input  logic [7:0]  addr_hi,
  input  logic [7:0]  ad_in,
  input  logic [7:0]  reg_map,
  input  logic [7:0]  mem_map,
  input  logic [7:0]  reg_rdata,
  input  logic [7:0]  mem_rdata,
  input  logic [7:0]  gpio_b,
  output logic [7:0]  ad_out,
  output logic [7:0]  wr_data,
  output logic [7:0]  portb_out,
  output logic        rd_en,
  output logic        wr_en,
  output logic        reg_hit,
  output logic        mem_hit,
  output logic        scratch_hit,
  output logic        plane,
  output logic [12:0] offset
);
  localparam logic [9:0] MAP_ID_OFS = 10'h000;
  localparam logic [9:0] MEM_ID_OFS = 10'h038;

  logic        rst, as_q, e_q, rw_q, valid_q, as_fall, wr_go;
  logic [15:0] addr_q;

  assign rst     = mem_map[3] ? rst_pin : ~rst_pin;
  assign as_fall = as_q & ~bus_as;
  assign wr_go   = e_q & ~bus_e & ~rw_q & (reg_hit | mem_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      as_q    <= 1'b0;
      e_q     <= 1'b0;
      rw_q    <= 1'b1;
      valid_q <= 1'b0;
      addr_q  <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      as_q  <= bus_as;
      e_q   <= bus_e;
      rw_q  <= bus_rw;
      wr_en <= wr_go;
      if (wr_go) wr_data <= ad_in;
      if (as_fall) begin
        addr_q  <= {addr_hi, ad_in};
        valid_q <= bus_ce & ~bus_sel_n;
      end
    end
  end

  assign reg_hit     = valid_q & (reg_map[7:6] == 2'b10) & (addr_q[15:10] == reg_map[5:0]);
  assign mem_hit     = valid_q & ~reg_hit & (addr_q[15:13] == mem_map[2:0]);
  assign offset      = reg_hit ? {3'b000, addr_q[9:0]} : (mem_hit ? addr_q[12:0] : 13'd0);
  assign plane       = mem_hit & addr_q[12];
  assign scratch_hit = reg_hit & (addr_q[9:4] == 6'h20);
  assign rd_en       = (reg_hit | mem_hit) & bus_e & bus_rw;
  assign portb_out   = mem_map[5] ? addr_q[7:0] : gpio_b;

  always_comb begin
    if (reg_hit && addr_q[9:0] == MAP_ID_OFS)      ad_out = ~reg_map;
    else if (reg_hit && addr_q[9:0] == MEM_ID_OFS) ad_out = ~mem_map;
    else if (reg_hit)                              ad_out = reg_rdata;
    else if (mem_hit)                              ad_out = mem_rdata;
    else                                           ad_out = 8'h00;
  end

  a_r1_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !as_fall |=> $stable(addr_q));
  a_r5_one_window: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_hit, mem_hit}));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  a_r8_pulse_on_hit: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(reg_hit | mem_hit));
endmodule

// File: tb/tb_mux_addr_decoder.sv
`timescale 1ns/1ps
module tb_mux_addr_decoder;
  logic clk = 0, rst_pin = 0, bus_as = 1, bus_e = 0, bus_rw = 1, bus_ce = 1, bus_sel_n = 0;
  logic [7:0] addr_hi = 0, ad_in = 0, reg_map = 8'h81, mem_map = 8'h07;
  logic [7:0] reg_rdata = 8'hA5, mem_rdata = 8'h5A, gpio_b = 8'h96;
  logic [7:0] ad_out, wr_data, portb_out;
  logic rd_en, wr_en, reg_hit, mem_hit, scratch_hit, plane;
  logic [12:0] offset;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mux_addr_decoder dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic latch(input logic [15:0] a, input logic ce, input logic sel_n);
    @(negedge clk); bus_as = 1; bus_ce = ce; bus_sel_n = sel_n;
    addr_hi = a[15:8]; ad_in = a[7:0]; bus_rw = 1; bus_e = 0;
    @(negedge clk); bus_as = 0;
    @(negedge clk);
  endtask

  task automatic read_chk(input logic [15:0] a, input logic ce, input logic sel_n);
    logic v, rh, mh;
    logic [12:0] off;
    logic [7:0] d;
    latch(a, ce, sel_n);
    ad_in = 8'h00; bus_e = 1; #1;
    v  = ce & ~sel_n;
    rh = v && reg_map[7:6] == 2'b10 && a[15:10] == reg_map[5:0];
    mh = v && !rh && a[15:13] == mem_map[2:0];
    off = rh ? {3'b000, a[9:0]} : (mh ? a[12:0] : 13'd0);
    if (rh && a[9:0] == 10'h000) d = ~reg_map;
    else if (rh && a[9:0] == 10'h038) d = ~mem_map;
    else if (rh) d = reg_rdata;
    else if (mh) d = mem_rdata;
    else d = 8'h00;
    chk("R2 R3 R4 R5 hits", {reg_hit, mem_hit}, {rh, mh});
    chk("R3 R4 offset", offset, off);
    chk("R4 plane", plane, mh & a[12]);
    chk("R9 scratch", scratch_hit, rh && a[9:4] == 6'h20);
    chk("R6 rd_en", rd_en, rh | mh);
    chk("R6 R7 read data", ad_out, d);
    chk("R10 portb", portb_out, mem_map[5] ? a[7:0] : gpio_b);
    @(negedge clk); bus_e = 0;
  endtask

  task automatic write_chk(input logic [15:0] a, input logic [7:0] d, input logic hit);
    latch(a, 1'b1, 1'b0);
    bus_rw = 0; ad_in = d; bus_e = 1; #1;
    chk("R6 no read in write", rd_en, 0);
    @(negedge clk); bus_e = 0;
    @(negedge clk); #1;
    chk("R8 write pulse", wr_en, hit);
    if (hit) chk("R8 write data", wr_data, d);
    @(negedge clk); bus_rw = 1; #1;
    chk("R8 pulse ends", wr_en, 0);
  endtask

  initial begin
    logic [7:0] rms[4] = '{8'h81, 8'h8C, 8'h98, 8'h41};
    logic [7:0] mms[4] = '{8'h07, 8'h03, 8'h23, 8'h07};
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset state", {reg_hit, mem_hit, wr_en, rd_en}, 4'b0000);
    @(negedge clk); rst_pin = 1;

    for (int c = 0; c < 4; c++) begin
      logic [15:0] base;
      reg_map = rms[c]; mem_map = mms[c];
      for (int h = 0; h < 256; h++) begin
        logic [7:0] hb, lb;
        hb = h[7:0];
        lb = hb * 8'd37 + 8'd11;
        read_chk({hb, lb}, 1'b1, 1'b0);
      end
      base = {reg_map[5:0], 10'h000};
      read_chk(base, 1'b1, 1'b0);            // R7 map readback
      read_chk(base | 16'h038, 1'b1, 1'b0);  // R7 map readback
      read_chk(base | 16'h200, 1'b1, 1'b0);  // R9 first scratch
      read_chk(base | 16'h20F, 1'b1, 1'b0);  // R9 last scratch
      read_chk(base | 16'h210, 1'b1, 1'b0);  // R9 past scratch
    end

    reg_map = 8'h81; mem_map = 8'h07;
    read_chk(16'h0400, 1'b0, 1'b0);  // R2 CE low
    read_chk(16'h0400, 1'b1, 1'b1);  // R2 SEL high
    read_chk(16'hF123, 1'b0, 1'b0);  // R2 CE low, memory window

    latch(16'hF456, 1'b1, 1'b0);
    addr_hi = 8'h04; ad_in = 8'h00;
    @(negedge clk); #1;
    chk("R1 address held", {offset, mem_hit}, {13'h1456, 1'b1});

    write_chk(16'hE010, 8'h3C, 1'b1);
    write_chk(16'h0605, 8'hC7, 1'b1);
    write_chk(16'h2000, 8'h11, 1'b0);

    @(negedge clk); rst_pin = 0; mem_map = 8'h0F;
    latch(16'h0410, 1'b1, 1'b0); #1;
    chk("R11 active-high pin low keeps state", reg_hit, 1);
    @(negedge clk); rst_pin = 1;
    @(negedge clk); #1;
    chk("R11 active-high reset clears", reg_hit, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule